// File: doc/BRIEF.md
# Rotating Windowed Register File

This block holds a circular array of physical 32-bit registers and shows a sliding view of 16 of them to the rest of the core. The view begins at a base pointer that counts in groups of four registers. A logical register number is turned into a physical entry by adding four times the base to it. The sum wraps at the end of the array, so a view near the top carries on at entry 0. Two combinational read ports and one write port all work through this mapping.

The base moves in two ways. A relative rotate adds a small signed step, counted in groups. An absolute load sets the base directly, and only the low bits of the value that fit the base are kept. Beside the base, the block keeps a mask with one bit per group, which marks the groups that hold a live frame. Single bits can be set or cleared by group number, and the whole mask can be loaded in one go.

All ports are plain control and data pins. Reads are combinational, and writes and commands take effect at the next clock edge. There is no valid/ready handshake because there is no back-pressure: every command presented in a cycle is taken in that cycle.

Top module: `rotwin_regfile`

## Requirements
- R1: After reset, `base_o` is 0, `wstart_o` is 16'h0001, and every logical register reads 0 on both read ports.
- R2: Logical register i maps to physical entry (base*4 + i) modulo 64. With base 15, logical 4 is physical 0 and logical 5 is physical 1.
- R3: Reads are combinational from the current base and the current contents. A write shows on the read ports from the cycle after its clock edge. A write given in the same cycle as a rotate uses the base from before the rotate.
- R4: When `rot_rel_en` is 1, the base becomes base + delta modulo 16. The 4-bit delta is two's complement, so 8..15 mean -8..-1. Sixteen steps of +1 return the base to where it started.
- R5: When `rot_abs_en` is 1, the base becomes bits [3:0] of the 8-bit `rot_abs_val`. If both rotate enables are 1 in the same cycle, the absolute load wins.
- R6: When neither rotate enable is 1, the base and the register contents other than the written entry stay unchanged.
- R7: `ws_set_en` sets bit (`ws_set_grp` mod 16) of the mask, and `ws_clr_en` clears bit (`ws_clr_grp` mod 16). Both can act in the same cycle on different groups. If both name the same group, the bit ends up cleared. With no mask command, the mask holds.
- R8: When `ws_load_en` is 1, the mask becomes `ws_load_val`, and any set or clear in that same cycle is ignored.
- R9: The two read ports are independent. When both select the same logical register, they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_lidx | input | 4 | Logical register for read port 0 |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_lidx | input | 4 | Logical register for read port 1 |
| rd1_data | output | 32 | Read port 1 data, combinational |
| wr_en | input | 1 | Write enable |
| wr_lidx | input | 4 | Logical register to write |
| wr_data | input | 32 | Write data |
| rot_rel_en | input | 1 | Relative rotate enable |
| rot_delta | input | 4 | Signed rotate step, in groups |
| rot_abs_en | input | 1 | Absolute base load enable |
| rot_abs_val | input | 8 | New base value; the low 4 bits are used |
| ws_set_en | input | 1 | Set one mask bit |
| ws_set_grp | input | 8 | Group to set; taken modulo 16 |
| ws_clr_en | input | 1 | Clear one mask bit |
| ws_clr_grp | input | 8 | Group to clear; taken modulo 16 |
| ws_load_en | input | 1 | Load the whole mask |
| ws_load_val | input | 16 | Mask value to load |
| base_o | output | 4 | Current base, in groups |
| wstart_o | output | 16 | Current live-group mask |

## Verification
The assertions assume that every enable and index is a known value at each rising edge and stays stable around that edge. Each rule that compares a value with its `$past` value also assumes that the commands seen in one cycle are the only ones that shape the state at the next edge. The bench meets both assumptions: it changes inputs only one time unit after a falling edge and clears every command field after each cycle. It also drives simultaneous rotate enables and overlapping set and clear only where a priority requirement defines the outcome. It never drives X or Z values onto the index inputs.

// File: rtl/rotwin_pkg.sv
package rotwin_pkg;

  // Base pointer update selected in a cycle
  typedef enum logic [1:0] {
    ROT_HOLD = 2'd0,
    ROT_REL  = 2'd1,
    ROT_ABS  = 2'd2
  } rot_op_e;

endpackage

// File: rtl/rotwin_addr_map.sv
// Logical-to-physical index translation: (base << group shift) + lidx,
// wrapping naturally because the physical size is a power of two.
module rotwin_addr_map #(
  parameter int BASE_W  = 4,
  parameter int LADDR_W = 4,
  parameter int PADDR_W = 6,
  parameter int GRP_SH  = 2
) (
  input  logic [BASE_W-1:0]  base,
  input  logic [LADDR_W-1:0] lidx,
  output logic [PADDR_W-1:0] pidx
);

  logic [PADDR_W-1:0] grp_start;

  always_comb begin
    grp_start = PADDR_W'({base, {GRP_SH{1'b0}}});
    pidx      = grp_start + PADDR_W'(lidx);
  end

endmodule

// File: rtl/rotwin_base_ctrl.sv
// Window base register: hold, signed relative step, or absolute load.
module rotwin_base_ctrl
  import rotwin_pkg::*;
#(
  parameter int BASE_W  = 4,
  parameter int DELTA_W = 4,
  parameter int ABS_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_en,
  input  logic [DELTA_W-1:0] delta,
  input  logic               abs_en,
  input  logic [ABS_W-1:0]   abs_val,
  output logic [BASE_W-1:0]  base_q
);

  rot_op_e           op;
  logic [31:0]       delta_ext;
  logic [31:0]       rel_sum;
  logic [BASE_W-1:0] base_d;

  always_comb begin
    if (abs_en)      op = ROT_ABS;
    else if (rel_en) op = ROT_REL;
    else             op = ROT_HOLD;
  end

  always_comb begin
    delta_ext = 32'($signed(delta));
    rel_sum   = 32'(base_q) + delta_ext;
    unique case (op)
      ROT_REL: base_d = rel_sum[BASE_W-1:0];
      ROT_ABS: base_d = BASE_W'(abs_val);
      default: base_d = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

endmodule

// File: rtl/rotwin_wstart.sv
// Live-group mask: per-group set and clear, or whole-mask load.
module rotwin_wstart #(
  parameter int NGRP   = 16,
  parameter int GIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [GIDX_W-1:0] set_grp,
  input  logic              clr_en,
  input  logic [GIDX_W-1:0] clr_grp,
  input  logic              load_en,
  input  logic [NGRP-1:0]   load_val,
  output logic [NGRP-1:0]   mask_q
);

  localparam int GW = $clog2(NGRP);

  logic [GW-1:0]   set_idx, clr_idx;
  logic [NGRP-1:0] set_vec, clr_vec, mask_d;

  always_comb begin
    set_idx = GW'(set_grp);
    clr_idx = GW'(clr_grp);
    set_vec = set_en ? (NGRP'(1) << set_idx) : '0;
    clr_vec = clr_en ? (NGRP'(1) << clr_idx) : '0;
    if (load_en) mask_d = load_val;
    else         mask_d = (mask_q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= NGRP'(1);
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/rotwin_storage.sv
// Physical register array: one write port, NRD combinational read ports.
module rotwin_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int NRD    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end

endmodule

// File: rtl/rotwin_regfile.sv
// Rotating windowed register file top level.
module rotwin_regfile #(
  parameter int DATA_W    = 32,
  parameter int PHYS_REGS = 64,
  parameter int VIS_REGS  = 16,
  parameter int GRP_SZ    = 4,
  parameter int DELTA_W   = 4,
  parameter int ABS_W     = 8,
  parameter int GIDX_W    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [$clog2(VIS_REGS)-1:0]           rd0_lidx,
  output logic [DATA_W-1:0]                     rd0_data,
  input  logic [$clog2(VIS_REGS)-1:0]           rd1_lidx,
  output logic [DATA_W-1:0]                     rd1_data,
  input  logic                                  wr_en,
  input  logic [$clog2(VIS_REGS)-1:0]           wr_lidx,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  rot_rel_en,
  input  logic [DELTA_W-1:0]                    rot_delta,
  input  logic                                  rot_abs_en,
  input  logic [ABS_W-1:0]                      rot_abs_val,
  input  logic                                  ws_set_en,
  input  logic [GIDX_W-1:0]                     ws_set_grp,
  input  logic                                  ws_clr_en,
  input  logic [GIDX_W-1:0]                     ws_clr_grp,
  input  logic                                  ws_load_en,
  input  logic [PHYS_REGS/GRP_SZ-1:0]           ws_load_val,
  output logic [$clog2(PHYS_REGS/GRP_SZ)-1:0]   base_o,
  output logic [PHYS_REGS/GRP_SZ-1:0]           wstart_o
);

  localparam int NGRP    = PHYS_REGS / GRP_SZ;
  localparam int BASE_W  = $clog2(NGRP);
  localparam int PADDR_W = $clog2(PHYS_REGS);
  localparam int LADDR_W = $clog2(VIS_REGS);
  localparam int GRP_SH  = $clog2(GRP_SZ);
  localparam int NRD     = 2;
  localparam int NMAP    = NRD + 1;  // read ports then the write port

  logic [BASE_W-1:0]                base_q;
  logic [NGRP-1:0]                  mask_q;
  logic [NMAP-1:0][LADDR_W-1:0]     map_lidx;
  logic [NMAP-1:0][PADDR_W-1:0]     map_pidx;
  logic [NRD-1:0][PADDR_W-1:0]      rd_pidx;
  logic [NRD-1:0][DATA_W-1:0]       rd_data;

  assign map_lidx[0] = rd0_lidx;
  assign map_lidx[1] = rd1_lidx;
  assign map_lidx[2] = wr_lidx;

  // Every port translates through the same pre-edge base.
  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rotwin_addr_map #(
      .BASE_W (BASE_W),
      .LADDR_W(LADDR_W),
      .PADDR_W(PADDR_W),
      .GRP_SH (GRP_SH)
    ) u_map (
      .base(base_q),
      .lidx(map_lidx[m]),
      .pidx(map_pidx[m])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rdsel
    assign rd_pidx[r] = map_pidx[r];
  end

  rotwin_base_ctrl #(
    .BASE_W (BASE_W),
    .DELTA_W(DELTA_W),
    .ABS_W  (ABS_W)
  ) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .rel_en (rot_rel_en),
    .delta  (rot_delta),
    .abs_en (rot_abs_en),
    .abs_val(rot_abs_val),
    .base_q (base_q)
  );

  rotwin_wstart #(
    .NGRP  (NGRP),
    .GIDX_W(GIDX_W)
  ) u_ws (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ws_set_en),
    .set_grp (ws_set_grp),
    .clr_en  (ws_clr_en),
    .clr_grp (ws_clr_grp),
    .load_en (ws_load_en),
    .load_val(ws_load_val),
    .mask_q  (mask_q)
  );

  rotwin_storage #(
    .DATA_W(DATA_W),
    .DEPTH (PHYS_REGS),
    .AW    (PADDR_W),
    .NRD   (NRD)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .waddr(map_pidx[NRD]),
    .wdata(wr_data),
    .raddr(rd_pidx),
    .rdata(rd_data)
  );

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];
  assign base_o   = base_q;
  assign wstart_o = mask_q;

endmodule

// File: rtl/rotwin_chk.sv
// Property checker bound to rotwin_regfile.
module rotwin_chk #(
  parameter int BASE_W  = 4,
  parameter int NGRP    = 16,
  parameter int LADDR_W = 4,
  parameter int DATA_W  = 32,
  parameter int DELTA_W = 4,
  parameter int ABS_W   = 8,
  parameter int GIDX_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LADDR_W-1:0] rd0_lidx,
  input logic [DATA_W-1:0]  rd0_data,
  input logic [LADDR_W-1:0] rd1_lidx,
  input logic [DATA_W-1:0]  rd1_data,
  input logic               rot_rel_en,
  input logic [DELTA_W-1:0] rot_delta,
  input logic               rot_abs_en,
  input logic [ABS_W-1:0]   rot_abs_val,
  input logic               ws_set_en,
  input logic [GIDX_W-1:0]  ws_set_grp,
  input logic               ws_clr_en,
  input logic [GIDX_W-1:0]  ws_clr_grp,
  input logic               ws_load_en,
  input logic [NGRP-1:0]    ws_load_val,
  input logic [BASE_W-1:0]  base_o,
  input logic [NGRP-1:0]    wstart_o
);

  localparam int GW = $clog2(NGRP);

  logic [BASE_W-1:0] rel_target;
  logic [BASE_W-1:0] abs_target;
  logic [GW-1:0]     s_idx, c_idx;

  assign rel_target = base_o + BASE_W'(32'($signed(rot_delta)));
  assign abs_target = BASE_W'(rot_abs_val);
  assign s_idx      = GW'(ws_set_grp);
  assign c_idx      = GW'(ws_clr_grp);

  AST_RST_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (base_o == '0 && wstart_o == NGRP'(1))); // R1

  AST_REL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_rel_en && !rot_abs_en) |=> (base_o == $past(rel_target))); // R4

  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rot_abs_en |=> (base_o == $past(abs_target))); // R5

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_rel_en && !rot_abs_en) |=> $stable(base_o)); // R6

  AST_WS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_set_en && !ws_load_en && !(ws_clr_en && c_idx == s_idx))
      |=> wstart_o[$past(s_idx)]); // R7

  AST_WS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_clr_en && !ws_load_en) |=> !wstart_o[$past(c_idx)]); // R7

  AST_WS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ws_set_en && !ws_clr_en && !ws_load_en) |=> $stable(wstart_o)); // R7

  AST_WS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ws_load_en |=> (wstart_o == $past(ws_load_val))); // R8

  AST_RD_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_lidx == rd1_lidx) |-> (rd0_data == rd1_data)); // R9

endmodule

bind rotwin_regfile rotwin_chk #(
  .BASE_W (BASE_W),
  .NGRP   (NGRP),
  .LADDR_W(LADDR_W),
  .DATA_W (DATA_W),
  .DELTA_W(DELTA_W),
  .ABS_W  (ABS_W),
  .GIDX_W (GIDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd0_lidx   (rd0_lidx),
  .rd0_data   (rd0_data),
  .rd1_lidx   (rd1_lidx),
  .rd1_data   (rd1_data),
  .rot_rel_en (rot_rel_en),
  .rot_delta  (rot_delta),
  .rot_abs_en (rot_abs_en),
  .rot_abs_val(rot_abs_val),
  .ws_set_en  (ws_set_en),
  .ws_set_grp (ws_set_grp),
  .ws_clr_en  (ws_clr_en),
  .ws_clr_grp (ws_clr_grp),
  .ws_load_en (ws_load_en),
  .ws_load_val(ws_load_val),
  .base_o     (base_o),
  .wstart_o   (wstart_o)
);

// File: tb/rotwin_regfile_tb_top.sv
`timescale 1ns/1ps
module rotwin_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd0_lidx = '0, rd1_lidx = '0, wr_lidx = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0, rot_rel_en = 1'b0, rot_abs_en = 1'b0;
  logic [3:0]  rot_delta = '0;
  logic [7:0]  rot_abs_val = '0, ws_set_grp = '0, ws_clr_grp = '0;
  logic        ws_set_en = 1'b0, ws_clr_en = 1'b0, ws_load_en = 1'b0;
  logic [15:0] ws_load_val = '0;
  logic [3:0]  base_o;
  logic [15:0] wstart_o;

  always #2 clk = ~clk;  // 250 MHz

  rotwin_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_lidx(rd0_lidx), .rd0_data(rd0_data),
    .rd1_lidx(rd1_lidx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_lidx(wr_lidx), .wr_data(wr_data),
    .rot_rel_en(rot_rel_en), .rot_delta(rot_delta),
    .rot_abs_en(rot_abs_en), .rot_abs_val(rot_abs_val),
    .ws_set_en(ws_set_en), .ws_set_grp(ws_set_grp),
    .ws_clr_en(ws_clr_en), .ws_clr_grp(ws_clr_grp),
    .ws_load_en(ws_load_en), .ws_load_val(ws_load_val),
    .base_o(base_o), .wstart_o(wstart_o)
  );

  typedef struct packed {
    logic [31:0] r0;
    logic [31:0] r1;
    logic [3:0]  b;
    logic [15:0] ws;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // Reference state built from the requirements
  logic [31:0] m_reg [64];
  logic [3:0]  m_base;
  logic [15:0] m_ws;

  // Next command (cleared after every cycle); read indices persist
  logic        c_we, c_rr, c_ra, c_ss, c_sc, c_ld;
  logic [3:0]  c_wl, c_dl, c_r0, c_r1;
  logic [31:0] c_wd;
  logic [7:0]  c_av, c_gs, c_gc;
  logic [15:0] c_lv;

  function automatic logic [31:0] model_rd(input logic [3:0] l);
    logic [5:0] p;
    p = {m_base, 2'b00} + {2'b00, l};
    return m_reg[p];
  endfunction

  task automatic clear_cmd();
    c_we = 0; c_rr = 0; c_ra = 0; c_ss = 0; c_sc = 0; c_ld = 0;
    c_wl = 0; c_dl = 0; c_wd = 0; c_av = 0; c_gs = 0; c_gc = 0; c_lv = 0;
  endtask

  // Driver: apply one cycle of commands, advance the model, queue the expectation
  task automatic cyc(input string tag);
    logic [5:0] wp;
    exp_t e;
    @(negedge clk);
    #1;
    wr_en = c_we; wr_lidx = c_wl; wr_data = c_wd;
    rot_rel_en = c_rr; rot_delta = c_dl;
    rot_abs_en = c_ra; rot_abs_val = c_av;
    ws_set_en = c_ss; ws_set_grp = c_gs;
    ws_clr_en = c_sc; ws_clr_grp = c_gc;
    ws_load_en = c_ld; ws_load_val = c_lv;
    rd0_lidx = c_r0; rd1_lidx = c_r1;
    @(posedge clk);
    wp = {m_base, 2'b00} + {2'b00, c_wl};
    if (c_we) m_reg[wp] = c_wd;
    if (c_ra)      m_base = c_av[3:0];
    else if (c_rr) m_base = m_base + c_dl;
    if (c_ld) m_ws = c_lv;
    else begin
      if (c_ss) m_ws[c_gs[3:0]] = 1'b1;
      if (c_sc) m_ws[c_gc[3:0]] = 1'b0;
    end
    e.r0 = model_rd(c_r0);
    e.r1 = model_rd(c_r1);
    e.b  = m_base;
    e.ws = m_ws;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    clear_cmd();
  endtask

  // Monitor: compare at the falling edge, after the inputs have settled
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (rd0_data !== e.r0 || rd1_data !== e.r1 || base_o !== e.b || wstart_o !== e.ws) begin
        n_bad++;
        $display("FAIL %s: got rd0=%h rd1=%h base=%h ws=%h, expected rd0=%h rd1=%h base=%h ws=%h",
                 t, rd0_data, rd1_data, base_o, wstart_o, e.r0, e.r1, e.b, e.ws);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got no end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    clear_cmd();
    c_r0 = 0; c_r1 = 0;
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    m_base = '0;
    m_ws = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across all logical registers
    for (int k = 0; k < 8; k++) begin
      c_r0 = 4'(2 * k); c_r1 = 4'(2 * k + 1);
      cyc("R1");
    end

    // R3: fill the window, each write visible the following cycle
    for (int k = 0; k < 16; k++) begin
      c_we = 1; c_wl = 4'(k); c_wd = 32'hA000_0000 + 32'(k * 17);
      c_r0 = 4'(k); c_r1 = 4'(15 - k);
      cyc("R3");
    end

    // R4: relative steps, positive and negative
    c_r0 = 0; c_r1 = 15;
    c_rr = 1; c_dl = 4'd1;  cyc("R4");
    c_rr = 1; c_dl = 4'hF;  cyc("R4");
    c_rr = 1; c_dl = 4'd8;  cyc("R4");
    c_rr = 1; c_dl = 4'd9;  cyc("R4");
    for (int k = 0; k < 16; k++) begin
      c_rr = 1; c_dl = 4'd1; cyc("R4");
    end

    // R5: absolute load with masking, and priority over relative
    c_ra = 1; c_av = 8'h2F; cyc("R5");
    c_ra = 1; c_av = 8'h03; c_rr = 1; c_dl = 4'd1; cyc("R5");
    c_ra = 1; c_av = 8'hFF; cyc("R5");

    // R2: window at base 15 wraps to physical 0 and 1
    c_r0 = 5; c_r1 = 4;
    c_we = 1; c_wl = 4'd5; c_wd = 32'h5555_0001; cyc("R2");
    c_we = 1; c_wl = 4'd4; c_wd = 32'h4444_0000; cyc("R2");
    c_r0 = 0; c_r1 = 1;
    c_ra = 1; c_av = 8'h00; cyc("R2");

    // R6: idle cycles keep base and contents
    c_r0 = 3; c_r1 = 12;
    repeat (3) cyc("R6");

    // R3: write in the same cycle as a rotate uses the old base
    c_r0 = 0; c_r1 = 2;
    c_we = 1; c_wl = 4'd2; c_wd = 32'h1234_5678; c_rr = 1; c_dl = 4'd2;
    cyc("R3");
    c_ra = 1; c_av = 8'h00; cyc("R3");

    // R7: mask set and clear
    c_ss = 1; c_gs = 8'h13; cyc("R7");
    c_sc = 1; c_gc = 8'h00; cyc("R7");
    c_ss = 1; c_gs = 8'h05; cyc("R7");
    c_ss = 1; c_gs = 8'h05; c_sc = 1; c_gc = 8'h05; cyc("R7");
    c_ss = 1; c_gs = 8'h06; c_sc = 1; c_gc = 8'h03; cyc("R7");
    cyc("R7");

    // R8: whole-mask load overrides set and clear
    c_ld = 1; c_lv = 16'hA5A5; c_ss = 1; c_gs = 8'h01; c_sc = 1; c_gc = 8'h00;
    cyc("R8");
    c_ld = 1; c_lv = 16'h0000; c_ss = 1; c_gs = 8'h0F; cyc("R8");

    // R9: both read ports on the same and on different registers
    c_r0 = 7; c_r1 = 7; cyc("R9");
    c_r0 = 2; c_r1 = 2; cyc("R9");
    c_r0 = 9; c_r1 = 2; cyc("R9");

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule